// File: doc/BRIEF.md
# Character Row Horizontal Scroll Engine

This block paces the sideways scroll of a single character row on a dot-matrix display. A host writes scroll commands, each carrying a two-bit direction code and a six-bit speed, and separately names the character row that is to move. A frame-start tick from the display timing sets the pace. The block keeps a position made of a pixel phase inside the current character cell and a leading column index. The column index covers the twenty visible columns and the two hidden buffer columns at indices 20 and 21.

The pixel datapath reads the pixel phase and the leading column to fetch and shift the row. Each time a whole character cell has moved past, the block raises a strobe for a fixed number of clock cycles. The host uses that strobe as its cue to load fresh characters into the hidden buffer columns.

Top module: `scroll_line_engine`

## Requirements
- R1: After a synchronous active-low reset, the leading column and pixel phase are 0, the done strobe is low, the engine is not moving and the active row is 0.
- R2: A command with direction code 2'b00 (home) sets the leading column and pixel phase to 0 at the next clock edge and halts motion. It also forgets the selected row.
- R3: Code 2'b10 (left) advances the leading column by one after every 6 one-pixel moves. Code 2'b01 (right) retreats it by one after every 6 moves. The pixel phase counts the moves made inside the current cell, 0 to 5.
- R4: While moving, one pixel move happens on every Nth frame tick, where N is the command's speed field. A speed of 0 makes no move. Clock cycles without a tick make no move.
- R5: A left or right command does not start motion. Motion starts on the first row write after that command, and the written row becomes the active row.
- R6: Code 2'b11 (halt) stops motion. The leading column and pixel phase then hold their values whatever ticks arrive.
- R7: After a halt, a row write restarts motion only if it names the active row. A write naming any other row is ignored. While the engine is moving, row writes do not change the active row.
- R8: The leading column stays within 0..21. Moving left from 21 gives 0, and moving right from 0 gives 21.
- R9: When a cell move completes, the done strobe is high from the next cycle for PULSE_LEN clock cycles (default 8).
- R10: A cell move that completes while the strobe is high reloads the strobe to its full length. The strobe stays high without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle scroll command write |
| cmd_dir | input | 2 | Direction code: 00 home, 01 right, 10 left, 11 halt |
| cmd_speed | input | 6 | Frame ticks per one-pixel move, 0 means still |
| row_valid | input | 1 | One-cycle character row write |
| row_sel | input | 3 | Character row named by the row write |
| frame_tick | input | 1 | One-cycle pulse at each frame start |
| pix_phase | output | 3 | Pixel moves made inside the current cell, 0..5 |
| lead_col | output | 5 | Leftmost visible character column, 0..21 |
| active_row | output | 3 | Row being scrolled |
| moving | output | 1 | Engine is advancing on frame ticks |
| char_done | output | 1 | Strobe after each full character move |

## Verification
The bench drives the column through both wrap points: left from 21 to 0 and right from 0 to 21. A design that wrapped at 31, or wrapped at the wrong end, would show a leading column outside 0..21 or a jump to the wrong index. It gives a halted row a restart write that names a different row, where a careless design would wrongly resume. It also sends a row write while no move command is pending, where a careless design would start unasked. It runs at speed 1 with ticks on every cycle, so that cell moves come faster than the strobe length. A design that re-triggered the strobe instead of reloading it would show a low cycle. A mismatch in the divide-by-N frame counter shows up as an off-by-one column after a counted run of ticks.

// File: rtl/scroll_pkg.sv
// Shared encodings for the character row scroll engine.
package scroll_pkg;
    typedef enum logic [1:0] {
        DIR_HOME  = 2'b00,
        DIR_RIGHT = 2'b01,
        DIR_LEFT  = 2'b10,
        DIR_HALT  = 2'b11
    } scroll_dir_e;
endpackage

// File: rtl/scroll_ctrl.sv
// Command and row-write sequencer.
// Decides when the engine is moving, in which direction, at which speed and on which row.
// Assumes that a command and a row write never fall in the same cycle (the command wins).
module scroll_ctrl
    import scroll_pkg::*;
#(
    parameter int ROW_W   = 3,
    parameter int SPEED_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_dir,
    input  logic [SPEED_W-1:0] cmd_speed,
    input  logic               row_valid,
    input  logic [ROW_W-1:0]   row_sel,
    output logic               running,
    output logic               go_left,
    output logic [SPEED_W-1:0] speed,
    output logic [ROW_W-1:0]   row_q,
    output logic               home_req
);
    logic armed;
    logic has_row;

    // A home command clears the position in the position keeper.
    always_comb home_req = cmd_valid && (scroll_dir_e'(cmd_dir) == DIR_HOME);

    // Run, arm and row bookkeeping, updated on command and row writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            armed   <= 1'b0;
            has_row <= 1'b0;
            go_left <= 1'b0;
            speed   <= '0;
            row_q   <= '0;
        end else if (cmd_valid) begin
            speed <= cmd_speed;
            case (scroll_dir_e'(cmd_dir))
                DIR_HOME: begin
                    running <= 1'b0;
                    armed   <= 1'b0;
                    has_row <= 1'b0;
                end
                DIR_RIGHT, DIR_LEFT: begin
                    running <= 1'b0;
                    armed   <= 1'b1;
                    go_left <= cmd_dir[1];
                end
                default: begin
                    running <= 1'b0;
                    armed   <= 1'b0;
                end
            endcase
        end else if (row_valid) begin
            if (armed) begin
                row_q   <= row_sel;
                running <= 1'b1;
                armed   <= 1'b0;
                has_row <= 1'b1;
            end else if (!running && has_row && (row_sel == row_q)) begin
                running <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/scroll_pacer.sv
// Frame divider: issues one pixel-move request every `speed` frame ticks while running.
// Assumes that a speed of zero means no motion. Any command restarts the count.
module scroll_pacer #(
    parameter int SPEED_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               running,
    input  logic [SPEED_W-1:0] speed,
    input  logic               frame_tick,
    output logic               step
);
    logic [SPEED_W-1:0] fcnt;
    logic               last;

    // The current tick is the Nth tick since the last move.
    always_comb begin
        last = (speed != '0) && (fcnt >= speed - SPEED_W'(1));
        step = running && !clear && frame_tick && last;
    end

    // Count frame ticks between moves.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !running) begin
            fcnt <= '0;
        end else if (frame_tick && (speed != '0)) begin
            fcnt <= last ? '0 : fcnt + SPEED_W'(1);
        end
    end
endmodule

// File: rtl/scroll_position.sv
// Keeps the pixel phase within a cell and the leading column, which wraps over NUM_COLS.
// Assumes that home and step are never high together (the pacer masks steps during commands).
module scroll_position #(
    parameter int CELL_PX  = 6,
    parameter int NUM_COLS = 22,
    localparam int PIX_W   = $clog2(CELL_PX),
    localparam int COL_W   = $clog2(NUM_COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             home,
    input  logic             step,
    input  logic             go_left,
    output logic [PIX_W-1:0] pix,
    output logic [COL_W-1:0] col,
    output logic             cell_done
);
    localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(CELL_PX - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_COLS - 1);

    logic [COL_W-1:0] col_next;

    // A move that finishes a cell, and the column it leads to.
    always_comb begin
        cell_done = step && (pix == PIX_LAST);
        if (go_left) col_next = (col == COL_LAST) ? '0 : col + COL_W'(1);
        else         col_next = (col == '0) ? COL_LAST : col - COL_W'(1);
    end

    // Position register update.
    always_ff @(posedge clk) begin
        if (!rst_n || home) begin
            pix <= '0;
            col <= '0;
        end else if (step) begin
            if (cell_done) begin
                pix <= '0;
                col <= col_next;
            end else begin
                pix <= pix + PIX_W'(1);
            end
        end
    end
endmodule

// File: rtl/scroll_strobe.sv
// Stretchable completion strobe: high for PULSE_LEN cycles after the last fire.
// Assumes PULSE_LEN >= 1. A fire during the strobe reloads it to the full length.
module scroll_strobe #(
    parameter int PULSE_LEN = 8,
    localparam int CNT_W    = $clog2(PULSE_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);
    logic [CNT_W-1:0] left_q;

    // Load on fire, else count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              left_q <= '0;
        else if (fire)           left_q <= CNT_W'(PULSE_LEN);
        else if (left_q != '0)   left_q <= left_q - CNT_W'(1);
    end

    // The strobe is high while the count is running.
    always_comb active = (left_q != '0);
endmodule

// File: rtl/scroll_line_engine.sv
// Top of the character row scroll engine: sequencer, frame divider, position keeper
// and completion strobe. Supplies offsets only; no pixel data passes through it.
module scroll_line_engine #(
    parameter int CELL_PX   = 6,
    parameter int NUM_COLS  = 22,
    parameter int ROW_W     = 3,
    parameter int SPEED_W   = 6,
    parameter int PULSE_LEN = 8,
    localparam int PIX_W    = $clog2(CELL_PX),
    localparam int COL_W    = $clog2(NUM_COLS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_dir,
    input  logic [SPEED_W-1:0] cmd_speed,
    input  logic               row_valid,
    input  logic [ROW_W-1:0]   row_sel,
    input  logic               frame_tick,
    output logic [PIX_W-1:0]   pix_phase,
    output logic [COL_W-1:0]   lead_col,
    output logic [ROW_W-1:0]   active_row,
    output logic               moving,
    output logic               char_done
);
    logic               go_left;
    logic [SPEED_W-1:0] speed;
    logic               home_req;
    logic               step;
    logic               cell_done;

    scroll_ctrl #(.ROW_W(ROW_W), .SPEED_W(SPEED_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_dir(cmd_dir), .cmd_speed(cmd_speed),
        .row_valid(row_valid), .row_sel(row_sel),
        .running(moving), .go_left(go_left), .speed(speed),
        .row_q(active_row), .home_req(home_req)
    );

    scroll_pacer #(.SPEED_W(SPEED_W)) u_pacer (
        .clk(clk), .rst_n(rst_n), .clear(cmd_valid), .running(moving),
        .speed(speed), .frame_tick(frame_tick), .step(step)
    );

    scroll_position #(.CELL_PX(CELL_PX), .NUM_COLS(NUM_COLS)) u_pos (
        .clk(clk), .rst_n(rst_n), .home(home_req), .step(step),
        .go_left(go_left), .pix(pix_phase), .col(lead_col), .cell_done(cell_done)
    );

    scroll_strobe #(.PULSE_LEN(PULSE_LEN)) u_strobe (
        .clk(clk), .rst_n(rst_n), .fire(cell_done), .active(char_done)
    );
endmodule

// File: rtl/scroll_line_checker.sv
// Property checker for scroll_line_engine, bound to every instance of it.
module scroll_line_checker #(
    parameter int ROW_W   = 3,
    parameter int SPEED_W = 6,
    parameter int PIX_W   = 3,
    parameter int COL_W   = 5,
    parameter int CELL_PX = 6,
    parameter int NUM_COLS = 22
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [1:0]         cmd_dir,
    input logic               frame_tick,
    input logic [PIX_W-1:0]   pix_phase,
    input logic [COL_W-1:0]   lead_col,
    input logic [ROW_W-1:0]   active_row,
    input logic               moving,
    input logic               char_done
);
    AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n) int'(lead_col) < NUM_COLS); // R8
    AST_PIX_RANGE: assert property (@(posedge clk) disable iff (!rst_n) int'(pix_phase) < CELL_PX); // R3
    AST_HOME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_dir == 2'b00) |=> (lead_col == '0 && pix_phase == '0 && !moving)); // R2
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!moving && !cmd_valid) |=> ($stable(lead_col) && $stable(pix_phase))); // R6
    AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_tick && !cmd_valid) |=> $stable(pix_phase) && $stable(lead_col)); // R4
    AST_COL_CHANGE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ((lead_col == $past(lead_col)) || char_done)); // R9
    AST_ROW_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (moving && !cmd_valid) |=> $stable(active_row)); // R7
endmodule

bind scroll_line_engine scroll_line_checker #(
    .ROW_W(ROW_W), .SPEED_W(SPEED_W), .PIX_W(PIX_W), .COL_W(COL_W),
    .CELL_PX(CELL_PX), .NUM_COLS(NUM_COLS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dir(cmd_dir),
    .frame_tick(frame_tick), .pix_phase(pix_phase), .lead_col(lead_col),
    .active_row(active_row), .moving(moving), .char_done(char_done)
);

// File: tb/sim_scroll_line_engine.sv
// Bench: directed corners plus seeded random stimulus, checked against a requirement model.
module sim_scroll_line_engine;
    localparam int PULSE = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_dir = 2'b00;
    logic [5:0] cmd_speed = 6'd0;
    logic       row_valid = 1'b0;
    logic [2:0] row_sel = 3'd0;
    logic       frame_tick = 1'b0;
    logic [2:0] pix_phase;
    logic [4:0] lead_col;
    logic [2:0] active_row;
    logic       moving;
    logic       char_done;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    scroll_line_engine u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dir(cmd_dir),
        .cmd_speed(cmd_speed), .row_valid(row_valid), .row_sel(row_sel),
        .frame_tick(frame_tick), .pix_phase(pix_phase), .lead_col(lead_col),
        .active_row(active_row), .moving(moving), .char_done(char_done)
    );

    // Requirement model state
    int  m_col, m_pix, m_row, m_speed, m_fcnt, m_pcnt;
    bit  m_run, m_arm, m_has, m_left;

    function automatic int col_after(int c, bit left);
        if (left) return (c == 21) ? 0 : c + 1;   // R8 left wrap
        return (c == 0) ? 21 : c - 1;             // R8 right wrap
    endfunction

    always @(posedge clk) begin
        bit step;
        if (!rst_n) begin
            m_col = 0; m_pix = 0; m_row = 0; m_speed = 0; m_fcnt = 0; m_pcnt = 0;
            m_run = 0; m_arm = 0; m_has = 0; m_left = 0;
        end else begin
            step = m_run && !cmd_valid && frame_tick && m_speed != 0 && m_fcnt == m_speed - 1;
            if (step && m_pix == 5) m_pcnt = PULSE;
            else if (m_pcnt > 0)    m_pcnt = m_pcnt - 1;
            if (cmd_valid || !m_run) m_fcnt = 0;
            else if (frame_tick && m_speed != 0) m_fcnt = (m_fcnt == m_speed - 1) ? 0 : m_fcnt + 1;
            if (cmd_valid && cmd_dir == 2'b00) begin
                m_col = 0; m_pix = 0;
            end else if (step) begin
                if (m_pix == 5) begin m_pix = 0; m_col = col_after(m_col, m_left); end
                else m_pix = m_pix + 1;
            end
            if (cmd_valid) begin
                m_speed = int'(cmd_speed);
                case (cmd_dir)
                    2'b00: begin m_run = 0; m_arm = 0; m_has = 0; end
                    2'b01, 2'b10: begin m_run = 0; m_arm = 1; m_left = cmd_dir[1]; end
                    default: begin m_run = 0; m_arm = 0; end
                endcase
            end else if (row_valid) begin
                if (m_arm) begin m_row = int'(row_sel); m_run = 1; m_arm = 0; m_has = 1; end
                else if (!m_run && m_has && int'(row_sel) == m_row) m_run = 1;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_model();
        chk("R3 R8 lead_col", int'(lead_col), m_col);
        chk("R3 pix_phase", int'(pix_phase), m_pix);
        chk("R9 R10 char_done", int'(char_done), (m_pcnt != 0) ? 1 : 0);
        chk("R5 R6 R7 moving", int'(moving), int'(m_run));
        chk("R5 R7 active_row", int'(active_row), m_row);
    endtask

    // One cycle of stimulus, driven at a falling edge, checked at the next falling edge.
    task automatic cyc(bit tk, bit cv, logic [1:0] d, logic [5:0] s, bit rv, logic [2:0] r);
        frame_tick = tk; cmd_valid = cv; cmd_dir = d; cmd_speed = s;
        row_valid = rv; row_sel = r;
        @(posedge clk);
        @(negedge clk);
        frame_tick = 1'b0; cmd_valid = 1'b0; row_valid = 1'b0;
        compare_model();
    endtask

    task automatic cmd(logic [1:0] d, logic [5:0] s); cyc(0, 1, d, s, 0, 3'd0); endtask
    task automatic roww(logic [2:0] r);               cyc(0, 0, 2'b00, 6'd0, 1, r); endtask
    task automatic ticks(int n, bit gap);
        for (int i = 0; i < n; i++) begin
            cyc(1, 0, 2'b00, 6'd0, 0, 3'd0);
            if (gap) cyc(0, 0, 2'b00, 6'd0, 0, 3'd0);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 lead_col", int'(lead_col), 0);
        chk("R1 pix_phase", int'(pix_phase), 0);
        chk("R1 char_done", int'(char_done), 0);
        chk("R1 moving", int'(moving), 0);
        chk("R1 active_row", int'(active_row), 0);

        // R5: a row write with no move command pending starts nothing
        roww(3'd3);
        chk("R5 idle row write", int'(moving), 0);
        // R5: left command alone does not move
        cmd(2'b10, 6'd2);
        ticks(4, 1);
        chk("R5 armed not moving", int'(moving), 0);
        chk("R5 armed col", int'(lead_col), 0);
        roww(3'd3);
        chk("R5 started", int'(moving), 1);
        chk("R5 row taken", int'(active_row), 3);
        // R4: speed 2, 12 ticks -> 6 moves -> one column
        ticks(11, 1);
        chk("R4 before cell end", int'(lead_col), 0);
        chk("R4 phase 5", int'(pix_phase), 5);
        cyc(1, 0, 2'b00, 6'd0, 0, 3'd0);
        chk("R3 left advance", int'(lead_col), 1);
        chk("R9 strobe up", int'(char_done), 1);
        // R6 halt holds position
        cmd(2'b11, 6'd1);
        ticks(10, 0);
        chk("R6 halted col", int'(lead_col), 1);
        chk("R6 halted phase", int'(pix_phase), 0);
        // R7 restart only with matching row
        roww(3'd5);
        chk("R7 mismatch ignored", int'(moving), 0);
        roww(3'd3);
        chk("R7 restart", int'(moving), 1);
        // R10 speed 1, ticks every cycle: strobe stays high across cell moves
        ticks(6, 0);
        for (int i = 0; i < 14; i++) begin
            cyc(1, 0, 2'b00, 6'd0, 0, 3'd0);
            chk("R10 strobe stretched", int'(char_done), 1);
        end
        // R2 home
        cmd(2'b00, 6'd0);
        chk("R2 home col", int'(lead_col), 0);
        chk("R2 home stop", int'(moving), 0);
        // R8 right wrap 0 -> 21
        cmd(2'b01, 6'd1);
        roww(3'd2);
        ticks(6, 1);
        chk("R8 right wrap", int'(lead_col), 21);
        // R8 left wrap 21 -> 0
        cmd(2'b00, 6'd0);
        cmd(2'b10, 6'd1);
        roww(3'd2);
        ticks(21 * 6, 0);
        chk("R8 reach 21", int'(lead_col), 21);
        ticks(6, 0);
        chk("R8 left wrap", int'(lead_col), 0);
        // R4 speed zero never moves
        cmd(2'b10, 6'd0);
        roww(3'd6);
        ticks(20, 0);
        chk("R4 speed zero", int'(pix_phase), 0);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 45)      cyc(1, 0, 2'b00, 6'd0, 0, 3'd0);
            else if (r < 49) cyc(0, 1, 2'($urandom_range(0, 3)), 6'($urandom_range(0, 3)), 0, 3'd0);
            else if (r < 56) cyc(0, 0, 2'b00, 6'd0, 1,
                                 ($urandom_range(0, 1) == 1) ? 3'(m_row) : 3'($urandom_range(0, 7)));
            else             cyc(0, 0, 2'b00, 6'd0, 0, 3'd0);
        end
        finish_run();
    end
endmodule